// File: doc/BRIEF.md
# Bridge Configuration Register Controller

This block holds the bridge-specific part of a type-1 configuration header for a PCI-to-PCI bridge. A requester sends single-dword reads and byte-enabled writes, each selected by a dword index into the 64-byte header. The block applies reset values, per-bit write masks and read-only constant fields. It drives the decoded I/O, memory and prefetchable window bounds, the command word and the bridge-control word to a downstream window decoder.

Two one-cycle events come out alongside the write response. A mapping-update pulse tells the decoder to rebuild its windows whenever a write touches a window-related byte. A secondary hot-reset pulse fires when the secondary-bus-reset control bit goes from 0 to 1. A build parameter chooses the reset pattern of the windows. The default pattern clears every range field. The forwarding-disabled pattern sets every base range field to all ones and every limit range field to zero, so that no window can match.

The request port is a small two-state machine. In ST_IDLE, `req_ready` is high, and an accepted request (transition IDLE_TO_RESP) performs the read or the write at that clock edge. In ST_RESP, `rsp_valid` is high for exactly one cycle, and the machine then returns unconditionally (transition RESP_TO_IDLE).

Top module: `bridge_cfg_regs`

## Requirements
- R1: After reset with the default pattern, the bus-number dword (index 6), the window range fields, both prefetchable upper dwords (indices 10, 11), the I/O upper dword (index 12) and the bridge-control word all read zero.
- R2: With DISABLE_FWD=1, reset leaves the I/O base nibble at 0xF and the limit nibble at 0, the memory and prefetchable base fields at 0xFFF and the limit fields at 0, and the upper dwords at zero. Dword 7 then reads 0x00A001F1.
- R3: Constant fields read back as follows:
  - dword 0 is {DEVICE_ID, VENDOR_ID};
  - dword 1 bits 31:16 read 0x00A0 (66 MHz and fast back-to-back capable);
  - dword 2 is {0x060400, REVISION};
  - dword 3 bits 23:16 are {MULTI_FUNC, 7'h01};
  - dword 7 bits 31:16 read 0x00A0.
- R4: The type nibbles are read-only. The I/O base and limit bytes read 0x1 in bits 3:0 and 11:8 of dword 7. The memory words read 0x0 in bits 3:0 and 19:16 of dword 8. The prefetchable words read 0x1 in bits 3:0 and 19:16 of dword 9.
- R5: A write updates only the byte lanes whose enable bit is set, with lane n covering data bits 8n+7:8n. Reads return the little-endian dword of the selected index. Indices 4, 5, 13 and 14, and the low half of dword 15, read zero and ignore writes.
- R6: `map_update` pulses in the response cycle of a write exactly when an enabled byte falls in one of these byte ranges: 0x04–0x05, 0x1C–0x1D, 0x20–0x33 or 0x3E–0x3F.
- R7: `sec_hot_reset` pulses in the response cycle of a write only when bridge-control bit 6 (dword 15 bit 22) was 0 before the write and is 1 after it.
- R8: Window outputs are decoded from the register fields as follows:
  - io_base = {io_upper_base, iobase[7:4], 12'h000} and io_limit = {io_upper_limit, iolimit[7:4], 12'hFFF};
  - mem_base = {membase[15:4], 20'h0} and mem_limit = {memlimit[15:4], 20'hFFFFF};
  - pref_base and pref_limit are built the same way, with the upper 32-bit dwords on top.
- R9: `req_ready` is high only in ST_IDLE. Every accepted request produces exactly one `rsp_valid` cycle on the following clock, and `req_ready` is low in that cycle.
- R10: Only command bits 0, 1, 2, 6 and 8 (mask 0x0147) and bridge-control bits 11:0 are writable. Dwords 6, 10, 11 and 12 are fully writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 4 | Dword index (byte offset / 4) |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| map_update | output | 1 | Window remap pulse |
| sec_hot_reset | output | 1 | Secondary bus hot-reset pulse |
| cmd_word | output | 16 | Command register |
| bctl_word | output | 16 | Bridge-control register |
| io_base | output | 32 | Decoded I/O window base |
| io_limit | output | 32 | Decoded I/O window limit |
| mem_base | output | 32 | Decoded memory window base |
| mem_limit | output | 32 | Decoded memory window limit |
| pref_base | output | 64 | Decoded prefetchable window base |
| pref_limit | output | 64 | Decoded prefetchable window limit |

## Verification
On every cycle the assertions check the following:
- each response is a single cycle that follows an accepted request;
- a remap pulse never appears without a write;
- a hot-reset pulse coincides with a real 0-to-1 change of the bridge-control reset bit;
- the command and bridge-control words hold steady when no write occurred.

Only the bench's sweep of every index against every byte-enable pattern can show the rest:
- which byte ranges actually raise the remap pulse;
- that the masks and read-only nibbles are exactly right;
- that both reset patterns land where they should.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;
    localparam int unsigned CFG_DWORDS = 16;
    localparam int unsigned IDX_W      = $clog2(CFG_DWORDS);

    localparam logic [IDX_W-1:0] IX_CMD    = 4'd1;
    localparam logic [IDX_W-1:0] IX_BUS    = 4'd6;
    localparam logic [IDX_W-1:0] IX_IOBL   = 4'd7;
    localparam logic [IDX_W-1:0] IX_MEM    = 4'd8;
    localparam logic [IDX_W-1:0] IX_PREF   = 4'd9;
    localparam logic [IDX_W-1:0] IX_PBU    = 4'd10;
    localparam logic [IDX_W-1:0] IX_PLU    = 4'd11;
    localparam logic [IDX_W-1:0] IX_IOU    = 4'd12;
    localparam logic [IDX_W-1:0] IX_BCTL   = 4'd15;
    localparam int unsigned      HOTRST_BIT = 16 + 6;

    typedef enum logic [0:0] {ST_IDLE, ST_RESP} port_state_e;

    function automatic logic [31:0] wmask_f(input logic [IDX_W-1:0] ix);
        case (ix)
            IX_CMD:                    return 32'h0000_0147;
            IX_BUS, IX_PBU, IX_PLU,
            IX_IOU:                    return 32'hFFFF_FFFF;
            IX_IOBL:                   return 32'h0000_F0F0;
            IX_MEM, IX_PREF:           return 32'hFFF0_FFF0;
            IX_BCTL:                   return 32'h0FFF_0000;
            default:                   return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] rstval_f(input logic [IDX_W-1:0] ix,
                                             input logic dis_fwd);
        if (!dis_fwd) return 32'h0;
        case (ix)
            IX_IOBL:         return 32'h0000_00F0;
            IX_MEM, IX_PREF: return 32'h0000_FFF0;
            default:         return 32'h0;
        endcase
    endfunction

    // Does any enabled byte land in a window-related byte range?
    function automatic logic window_hit_f(input logic [IDX_W-1:0] ix,
                                          input logic [3:0] be);
        case (ix)
            IX_CMD, IX_IOBL:                      return |be[1:0];
            IX_MEM, IX_PREF, IX_PBU, IX_PLU, IX_IOU: return |be;
            IX_BCTL:                              return |be[3:2];
            default:                              return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/bcfg_port_fsm.sv
module bcfg_port_fsm
    import bcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic rsp_valid,
    output logic wr_en,
    output logic rd_en
);
    port_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;  // IDLE_TO_RESP
            ST_RESP: state_d = ST_IDLE;                 // RESP_TO_IDLE
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        wr_en     = req_ready && req_valid && req_write;
        rd_en     = req_ready && req_valid && !req_write;
    end

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9
    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready)); // R9
endmodule

// File: rtl/bcfg_regs.sv
module bcfg_regs
    import bcfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'hABCD,
    parameter logic [15:0] DEVICE_ID   = 16'h1234,
    parameter logic [7:0]  REVISION    = 8'h01,
    parameter bit          MULTI_FUNC  = 1'b0,
    parameter bit          DISABLE_FWD = 1'b0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd_data,
    output logic              map_update,
    output logic              hot_reset,
    output logic [15:0]       cmd_word,
    output logic [15:0]       bctl_word,
    output logic [31:0]       io_base,
    output logic [31:0]       io_limit,
    output logic [31:0]       mem_base,
    output logic [31:0]       mem_limit,
    output logic [63:0]       pref_base,
    output logic [63:0]       pref_limit
);
    localparam logic [15:0] STAT_CAPS  = 16'h00A0;
    localparam logic [23:0] CLASS_P2P  = 24'h060400;

    function automatic logic [31:0] fixed_f(input logic [IDX_W-1:0] ix);
        case (ix)
            4'd0:    return {DEVICE_ID, VENDOR_ID};
            IX_CMD:  return {STAT_CAPS, 16'h0};
            4'd2:    return {CLASS_P2P, REVISION};
            4'd3:    return {8'h00, MULTI_FUNC, 7'h01, 16'h0};
            IX_IOBL: return {STAT_CAPS, 16'h0101};
            IX_PREF: return 32'h0001_0001;
            default: return 32'h0;
        endcase
    endfunction

    logic [31:0] q    [CFG_DWORDS];
    logic [31:0] view [CFG_DWORDS];
    logic [31:0] merged;

    genvar g;
    generate
        for (g = 0; g < CFG_DWORDS; g++) begin : g_view
            assign view[g] = (q[g] & wmask_f(IDX_W'(g))) | fixed_f(IDX_W'(g));
        end
    endgenerate

    always_comb begin
        merged = q[idx];
        for (int b = 0; b < 4; b++)
            if (be[b]) merged[8*b +: 8] = wdata[8*b +: 8];
        merged = merged & wmask_f(idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CFG_DWORDS; i++)
                q[i] <= rstval_f(IDX_W'(i), DISABLE_FWD);
            rd_data    <= '0;
            map_update <= 1'b0;
            hot_reset  <= 1'b0;
        end else begin
            map_update <= wr_en && window_hit_f(idx, be);
            hot_reset  <= wr_en && (idx == IX_BCTL) &&
                          !q[IX_BCTL][HOTRST_BIT] && merged[HOTRST_BIT];
            if (wr_en) q[idx] <= merged;
            if (rd_en)      rd_data <= view[idx];
            else if (wr_en) rd_data <= '0;
        end
    end

    assign cmd_word   = view[IX_CMD][15:0];
    assign bctl_word  = view[IX_BCTL][31:16];
    assign io_base    = {view[IX_IOU][15:0],  view[IX_IOBL][7:4],   12'h000};
    assign io_limit   = {view[IX_IOU][31:16], view[IX_IOBL][15:12], 12'hFFF};
    assign mem_base   = {view[IX_MEM][15:4],  20'h0};
    assign mem_limit  = {view[IX_MEM][31:20], 20'hFFFFF};
    assign pref_base  = {view[IX_PBU], view[IX_PREF][15:4],  20'h0};
    assign pref_limit = {view[IX_PLU], view[IX_PREF][31:20], 20'hFFFFF};

    AST_HOTRST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        hot_reset |-> (bctl_word[6] && !$past(bctl_word[6]))); // R7
    AST_UPDATE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        map_update |-> $past(wr_en)); // R6
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(bctl_word) && $stable(cmd_word))); // R5
endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
    import bcfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'hABCD,
    parameter logic [15:0] DEVICE_ID   = 16'h1234,
    parameter logic [7:0]  REVISION    = 8'h01,
    parameter bit          MULTI_FUNC  = 1'b0,
    parameter bit          DISABLE_FWD = 1'b0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              map_update,
    output logic              sec_hot_reset,
    output logic [15:0]       cmd_word,
    output logic [15:0]       bctl_word,
    output logic [31:0]       io_base,
    output logic [31:0]       io_limit,
    output logic [31:0]       mem_base,
    output logic [31:0]       mem_limit,
    output logic [63:0]       pref_base,
    output logic [63:0]       pref_limit
);
    logic wr_en, rd_en;

    bcfg_port_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .wr_en     (wr_en),
        .rd_en     (rd_en)
    );

    bcfg_regs #(
        .VENDOR_ID   (VENDOR_ID),
        .DEVICE_ID   (DEVICE_ID),
        .REVISION    (REVISION),
        .MULTI_FUNC  (MULTI_FUNC),
        .DISABLE_FWD (DISABLE_FWD)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .idx        (req_idx),
        .be         (req_be),
        .wdata      (req_wdata),
        .rd_data    (rsp_rdata),
        .map_update (map_update),
        .hot_reset  (sec_hot_reset),
        .cmd_word   (cmd_word),
        .bctl_word  (bctl_word),
        .io_base    (io_base),
        .io_limit   (io_limit),
        .mem_base   (mem_base),
        .mem_limit  (mem_limit),
        .pref_base  (pref_base),
        .pref_limit (pref_limit)
    );
endmodule

// File: tb/sim_bridge_cfg_regs.sv
`timescale 1ns/1ps
module sim_bridge_cfg_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_idx = '0, req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, map_update, sec_hot_reset;
    logic [31:0] rsp_rdata, io_base, io_limit, mem_base, mem_limit;
    logic [15:0] cmd_word, bctl_word;
    logic [63:0] pref_base, pref_limit;

    logic        r1_ready, r1_rvalid, r1_upd, r1_hot;
    logic [31:0] r1_rdata, r1_iob, r1_iol, r1_mb, r1_ml;
    logic [15:0] r1_cmd, r1_bctl;
    logic [63:0] r1_pb, r1_pl;

    bridge_cfg_regs u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_idx(req_idx), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .map_update(map_update), .sec_hot_reset(sec_hot_reset),
        .cmd_word(cmd_word), .bctl_word(bctl_word), .io_base(io_base),
        .io_limit(io_limit), .mem_base(mem_base), .mem_limit(mem_limit),
        .pref_base(pref_base), .pref_limit(pref_limit));

    bridge_cfg_regs #(.MULTI_FUNC(1'b1), .DISABLE_FWD(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r1_ready),
        .req_write(req_write), .req_idx(req_idx), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(r1_rvalid), .rsp_rdata(r1_rdata),
        .map_update(r1_upd), .sec_hot_reset(r1_hot),
        .cmd_word(r1_cmd), .bctl_word(r1_bctl), .io_base(r1_iob),
        .io_limit(r1_iol), .mem_base(r1_mb), .mem_limit(r1_ml),
        .pref_base(r1_pb), .pref_limit(r1_pl));

    int nvec = 0, nfail = 0;
    logic [31:0] sh [16];

    function automatic logic [31:0] bwm(int ix);  // R10 / R4 masks
        case (ix)
            1: return 32'h0000_0147;
            6, 10, 11, 12: return 32'hFFFF_FFFF;
            7: return 32'h0000_F0F0;
            8, 9: return 32'hFFF0_FFF0;
            15: return 32'h0FFF_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] bfix(int ix, bit mf);  // R3 / R4 constants
        case (ix)
            0: return 32'h1234_ABCD;
            1: return 32'h00A0_0000;
            2: return 32'h0604_0001;
            3: return mf ? 32'h0081_0000 : 32'h0001_0000;
            7: return 32'h00A0_0101;
            9: return 32'h0001_0001;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] ev(int ix);
        return (sh[ix] & bwm(ix)) | bfix(ix, 1'b0);
    endfunction

    function automatic bit exp_hit(int ix, logic [3:0] be);  // R6 byte ranges
        bit h = 0;
        for (int b = 0; b < 4; b++) begin
            int a = ix * 4 + b;
            if (be[b] && ((a >= 4 && a <= 5) || (a >= 28 && a <= 29) ||
                          (a >= 32 && a <= 51) || (a >= 62 && a <= 63))) h = 1;
        end
        return h;
    endfunction

    task automatic check(string rq, logic [63:0] act, logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic xfer(bit wr, int ix, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_idx = 4'(ix);
        req_be = be; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_windows();  // R8, R10
        check("R8 io_base",  io_base,  {sh[12][15:0],  sh[7][7:4],   12'h000});
        check("R8 io_limit", io_limit, {sh[12][31:16], sh[7][15:12], 12'hFFF});
        check("R8 mem_base", mem_base, {sh[8][15:4],  20'h0});
        check("R8 mem_limit", mem_limit, {sh[8][31:20], 20'hFFFFF});
        check("R8 pref_base", pref_base, {sh[10], sh[9][15:4], 20'h0});
        check("R8 pref_limit", pref_limit, {sh[11], sh[9][31:20], 20'hFFFFF});
        check("R10 cmd_word", cmd_word, sh[1][15:0] & 16'h0147);
        check("R10 bctl_word", bctl_word, sh[15][31:16] & 16'h0FFF);
    endtask

    task automatic do_write(int ix, logic [3:0] be, logic [31:0] d);
        logic [31:0] m;
        bit old_b, new_b;
        m = sh[ix];
        for (int b = 0; b < 4; b++) if (be[b]) m[8*b +: 8] = d[8*b +: 8];
        old_b = sh[15][22];
        sh[ix] = m & bwm(ix);
        new_b = sh[15][22];
        xfer(1'b1, ix, be, d);
        check("R9 rsp_valid", rsp_valid, 1);
        check("R9 req_ready low", req_ready, 0);
        check("R6 map_update", map_update, exp_hit(ix, be));
        check("R7 sec_hot_reset", sec_hot_reset, (!old_b && new_b));
        check_windows();
    endtask

    task automatic do_read(int ix, string rq);
        xfer(1'b0, ix, 4'h0, 32'h0);
        check("R9 rsp_valid", rsp_valid, 1);
        check(rq, rsp_rdata, ev(ix));
        check("R6 no update on read", map_update, 0);
    endtask

    bit done = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) sh[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R9 ready in idle", req_ready, 1);
        check("R9 no rsp in idle", rsp_valid, 0);
        check_windows();  // R1 reset windows all zero
        // R2: forwarding-disabled reset pattern on u1
        check("R2 io_base",  r1_iob, 32'h0000_F000);
        check("R2 io_limit", r1_iol, 32'h0000_0FFF);
        check("R2 mem_base", r1_mb, 32'hFFF0_0000);
        check("R2 mem_limit", r1_ml, 32'h000F_FFFF);
        check("R2 pref_base", r1_pb, 64'h0000_0000_FFF0_0000);
        check("R2 pref_limit", r1_pl, 64'h0000_0000_000F_FFFF);
        // R1 / R3 / R4 reset readback of every index
        for (int ix = 0; ix < 16; ix++) begin
            do_read(ix, "R1 R3 R4 reset read");
            if (ix == 3) check("R3 multifunction kept", r1_rdata, 32'h0081_0000);
            if (ix == 7) check("R2 dword7", r1_rdata, 32'h00A0_01F1);
        end
        // R5 R6 R7 R10: every index against every byte-enable pattern
        for (int ix = 0; ix < 16; ix++) begin
            for (int be = 0; be < 16; be++) begin
                logic [31:0] d;
                d = 32'h9E37_79B9 * 32'(ix * 16 + be + 1);
                do_write(ix, 4'(be), d);
                do_read(ix, "R5 lane readback");
            end
        end
        // R7: explicit edge cases on the secondary reset bit
        do_write(15, 4'b0100, 32'h0000_0000);
        do_write(15, 4'b0100, 32'h0040_0000);  // rising -> pulse
        do_write(15, 4'b0100, 32'h0040_0000);  // held -> no pulse
        do_write(15, 4'b1000, 32'hFF00_0000);  // other lane -> no pulse
        do_write(15, 4'b0011, 32'h0000_FFFF);  // R5 low half ignored, R6 no update
        do_read(15, "R5 bctl readback");
        // R8: distinct window values
        do_write(7, 4'b0011, 32'h0000_A050);
        do_write(12, 4'b1111, 32'h1234_0001);
        do_write(8, 4'b1111, 32'hC000_8000);
        do_write(9, 4'b1111, 32'hFFF0_1230);
        do_write(10, 4'b1111, 32'h0000_0002);
        do_write(11, 4'b1111, 32'h0000_0003);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule